// File: doc/BRIEF.md
# IDE DMA Strobe and Acknowledge Controller

This block runs the device-facing side of an IDE DMA burst. When the attached drive raises its request line, the controller raises acknowledge and emits a train of read or write strobes. The width of each strobe and the idle gap after it come from programmable clock-count fields. During the final cycle of each strobe the controller samples the request line. If the request is still present, a further strobe follows after the recovery gap. If it is gone, acknowledge is released one clock after the strobe falls. The data path receives a single-cycle transfer pulse for every strobe.

Two timing sets are provided, a base set and a fast set. A fast-enable bit turns on the fast set. A second bit limits the fast set to DMA strobes, so single programmed-I/O (PIO) strobes keep the base timing. This suits drives whose DMA timing is tighter than their PIO timing. A PIO strobe is requested with a one-cycle go input. It produces one strobe with no acknowledge. An external stop input ends a DMA burst at the next strobe boundary, as a dropped request would.

Top module: `ide_dma_strobe_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after its release, `dev_ack`, `rd_stb`, `wr_stb` and `xfer` are all 0.
- R2: If the block is idle and `dev_req` is high at a clock edge, `dev_ack` and one strobe rise on that edge. The strobe is `wr_stb` when `dir_write`=1 and `rd_stb` when it is 0. The other strobe stays 0 for the whole burst, and the two strobes are never high together.
- R3: Each strobe stays high for A+1 cycles, where A is the selected active field. When another strobe follows in the same burst, the gap between them is R+1 cycles, where R is the selected recovery field.
- R4: `xfer` is high for exactly one cycle per strobe. That cycle is the last cycle in which the strobe is high.
- R5: `dev_req` is sampled in the last active cycle of each strobe. If it is 1 and `stop_req` is 0, the next strobe rises R+1 cycles after the current strobe falls.
- R6: If `dev_req` is 0 at that sample, no further strobe follows. `dev_ack` falls one clock after the strobe falls.
- R7: If `stop_req` is 1 at that sample, the burst ends exactly as in R6, even while `dev_req` stays high.
- R8: After a burst has ended, no new burst starts until `dev_req` has been seen at 0 and then at 1 again.
- R9: Timing selection works as follows. With `fast_en`=0, every strobe uses `base_act`/`base_rec`. With `fast_en`=1 and `dma_only`=0, every strobe uses `fast_act`/`fast_rec`. With `fast_en`=1 and `dma_only`=1, DMA strobes use the fast fields and PIO strobes use the base fields.
- R10: A `pio_go` pulse while the block is idle gives one strobe, selected by `pio_write`. `dev_ack` stays 0 throughout. If `dev_req` is also high in that cycle, a DMA burst starts instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | 1 | DMA request from the drive |
| dir_write | input | 1 | DMA direction: 1 pulses the write strobe, 0 the read strobe |
| stop_req | input | 1 | Ends the DMA burst at the next strobe boundary |
| pio_go | input | 1 | Starts one PIO strobe when idle |
| pio_write | input | 1 | PIO direction: 1 write strobe, 0 read strobe |
| fast_en | input | 1 | Enables the fast timing set |
| dma_only | input | 1 | Restricts the fast timing set to DMA strobes |
| base_act | input | TW | Base active width minus one, in clocks |
| base_rec | input | TW | Base recovery width minus one, in clocks |
| fast_act | input | TW | Fast active width minus one, in clocks |
| fast_rec | input | TW | Fast recovery width minus one, in clocks |
| dev_ack | output | 1 | DMA acknowledge to the drive |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| xfer | output | 1 | One-cycle pulse per strobe to the data path |

## Verification
The hardest case to reach is a burst ended by `stop_req` while `dev_req` stays high. Only there does the block have to hold off a restart (R8) with the request still asserted. The bench raises stop in the final active cycle of the last strobe and keeps the request high for R+4 further cycles, checking that acknowledge and both strobes stay low. It then drops the request for one cycle, and the next burst starts cleanly. Runs sweep every combination of the two timing-select bits, the active and recovery fields from 0 to 3, both directions and burst lengths of one to three strobes. They finish with a run at the widest field values, and every cycle is compared with an arithmetic timeline.

// File: rtl/ide_dma_strobe_ctrl.sv
module ide_dma_strobe_ctrl #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_req,
  input  logic          dir_write,
  input  logic          stop_req,
  input  logic          pio_go,
  input  logic          pio_write,
  input  logic          fast_en,
  input  logic          dma_only,
  input  logic [TW-1:0] base_act,
  input  logic [TW-1:0] base_rec,
  input  logic [TW-1:0] fast_act,
  input  logic [TW-1:0] fast_rec,
  output logic          dev_ack,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          xfer
);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_REC} st_t;

  st_t           st;
  logic [TW-1:0] cnt;
  logic          is_dma, wr_q, cont, armed;

  wire dma_fast  = fast_en;
  wire pio_fast  = fast_en & ~dma_only;
  wire start_dma = (st == S_IDLE) && dev_req && armed;
  wire start_pio = (st == S_IDLE) && !start_dma && pio_go;
  wire fast_new  = start_dma ? dma_fast : pio_fast;
  wire fast_cur  = is_dma ? dma_fast : pio_fast;

  wire [TW-1:0] act_new = fast_new ? fast_act : base_act;
  wire [TW-1:0] act_cur = fast_cur ? fast_act : base_act;
  wire [TW-1:0] rec_cur = fast_cur ? fast_rec : base_rec;

  wire act_end = (st == S_ACT) && (cnt == '0);
  wire keep    = is_dma && dev_req && !stop_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      is_dma  <= 1'b0;
      wr_q    <= 1'b0;
      cont    <= 1'b0;
      armed   <= 1'b1;
      dev_ack <= 1'b0;
    end else begin
      if (!dev_req)
        armed <= 1'b1;
      else if (act_end && is_dma && !keep)
        armed <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_dma) begin
            st      <= S_ACT;
            cnt     <= act_new;
            is_dma  <= 1'b1;
            wr_q    <= dir_write;
            dev_ack <= 1'b1;
          end else if (start_pio) begin
            st     <= S_ACT;
            cnt    <= act_new;
            is_dma <= 1'b0;
            wr_q   <= pio_write;
          end
        end
        S_ACT: begin
          if (cnt == '0) begin
            st   <= S_REC;
            cnt  <= rec_cur;
            cont <= keep;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_REC: begin
          if (!cont)
            dev_ack <= 1'b0;
          if (cnt == '0) begin
            st  <= cont ? S_ACT : S_IDLE;
            cnt <= act_cur;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_stb = (st == S_ACT) && !wr_q;
  assign wr_stb = (st == S_ACT) && wr_q;
  assign xfer   = act_end;

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  assert_xfer_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer);

  assert_xfer_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (rd_stb || wr_stb));

  assert_strobe_ends_on_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_stb || wr_stb) |-> $past(xfer));

  assert_ack_drop_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_ack) |-> (!rd_stb && !wr_stb && $past(!rd_stb && !wr_stb)));

  assert_ack_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_ack) |-> $past(dev_req));

endmodule

// File: tb/ide_dma_strobe_ctrl_tb.sv
module ide_dma_strobe_ctrl_tb;
  localparam int PERIOD = 10;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_req = 1'b0, dir_write = 1'b0, stop_req = 1'b0;
  logic pio_go = 1'b0, pio_write = 1'b0, fast_en = 1'b0, dma_only = 1'b0;
  logic [TW-1:0] base_act = '0, base_rec = '0, fast_act = '0, fast_rec = '0;
  logic dev_ack, rd_stb, wr_stb, xfer;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ide_dma_strobe_ctrl #(.TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dir_write(dir_write),
    .stop_req(stop_req), .pio_go(pio_go), .pio_write(pio_write),
    .fast_en(fast_en), .dma_only(dma_only), .base_act(base_act),
    .base_rec(base_rec), .fast_act(fast_act), .fast_rec(fast_rec),
    .dev_ack(dev_ack), .rd_stb(rd_stb), .wr_stb(wr_stb), .xfer(xfer));

  task automatic chk(input string req, input string what, input logic act, input logic exp, input int t);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", req, what, t, act, exp);
    end
  endtask

  task automatic run_seq(input bit dma, input bit wr, input bit use_stop, input bit also_pio,
                         input int n, input int a, input int r);
    int p, tl, cnt;
    logic es, ex, ea;
    p  = a + r + 2;
    cnt = dma ? n : 1;
    tl = 1 + (cnt - 1) * p + a;
    @(negedge clk);
    dir_write = wr;
    pio_write = wr;
    if (dma) dev_req = 1'b1;
    if (!dma || also_pio) pio_go = 1'b1;
    for (int t = 1; t <= tl + r + 4; t++) begin
      @(negedge clk);
      pio_go = 1'b0;
      es = 1'b0;
      ex = 1'b0;
      for (int i = 0; i < cnt; i++) begin
        if (t >= 1 + i * p && t <= 1 + i * p + a) es = 1'b1;
        if (t == 1 + i * p + a) ex = 1'b1;
      end
      ea = dma && (t <= tl + 1);
      chk("R3", wr ? "wr_stb width/gap" : "rd_stb width/gap", wr ? wr_stb : rd_stb, es, t);
      chk("R2", "idle strobe", wr ? rd_stb : wr_stb, 1'b0, t);
      chk("R4", "xfer", xfer, ex, t);
      if (dma) chk(use_stop ? "R7" : "R6", "dev_ack", dev_ack, ea, t);
      else     chk("R10", "pio dev_ack", dev_ack, 1'b0, t);
      if (dma && t == tl) begin
        if (use_stop) stop_req = 1'b1;
        else          dev_req  = 1'b0;
      end
      if (t == tl + 1) stop_req = 1'b0;
    end
    if (dma && use_stop) chk("R8", "no restart while req held", dev_ack, 1'b0, tl + r + 4);
    dev_req = 1'b0;
    stop_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int fa, fr, da, dr, pa, pr;
    repeat (3) @(negedge clk);
    chk("R1", "dev_ack in reset", dev_ack, 1'b0, 0);
    chk("R1", "rd_stb in reset", rd_stb, 1'b0, 0);
    chk("R1", "wr_stb in reset", wr_stb, 1'b0, 0);
    chk("R1", "xfer in reset", xfer, 1'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "dev_ack after reset", dev_ack, 1'b0, 1);
    chk("R1", "strobes after reset", rd_stb | wr_stb, 1'b0, 1);

    for (int m = 0; m < 4; m++) begin
      fast_en  = m[0];
      dma_only = m[1];
      for (int ba = 0; ba < 4; ba++) begin
        for (int br = 0; br < 4; br++) begin
          fa = (ba + 2) % 4;
          fr = (br + 1) % 4;
          base_act = TW'(ba); base_rec = TW'(br);
          fast_act = TW'(fa); fast_rec = TW'(fr);
          da = fast_en ? fa : ba;
          dr = fast_en ? fr : br;
          pa = (fast_en && !dma_only) ? fa : ba;
          pr = (fast_en && !dma_only) ? fr : br;
          for (int w = 0; w < 2; w++) begin
            // R5 R9: multi-strobe DMA with the selected timing
            run_seq(1'b1, w[0], ((ba + br) % 3) == 0, (br == 2), 1 + (ba % 3), da, dr);
            // R9 R10: single PIO strobe with its own timing selection
            run_seq(1'b0, w[0], 1'b0, 1'b0, 1, pa, pr);
          end
        end
      end
    end

    fast_en = 1'b0; dma_only = 1'b0;
    base_act = 4'd15; base_rec = 4'd15;
    run_seq(1'b1, 1'b1, 1'b0, 1'b0, 2, 15, 15);
    run_seq(1'b1, 1'b0, 1'b1, 1'b0, 2, 15, 15);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule